// File: doc/BRIEF.md
# Capture and Compare Controller

This block is the control and status front end of a register-snapshot engine. Software reaches it over a simple word-wide register bus. Through that bus it picks the engine function (plain capture, or CRC compare) and the data sink, turns the list engine on and off, and fires single passes with a software trigger. A companion list-walker receives a one-cycle start strobe. It streams each fetched word back with a valid flag and ends the pass with a done strobe.

In compare mode the controller folds every word of a pass into a CRC-32. When the pass closes, it checks the result against the CRC kept from the previous pass and then stores the new value as the reference. The first compare pass after the list is enabled has no valid reference, so it always reports an error. The next pass clears the flag if the data has not changed. Mismatches show in a status bit and in a sticky interrupt-status bit that software clears by writing 1. A level interrupt is raised while any enabled status bit is set.

Top module: `snap_ctrl`

## Requirements
- R1: After reset the list enable, config, interrupt enable and interrupt status are 0. Status reads 0x10 (bit 4 ready = 1, bit 0 error = 0), `irq` is 0, and offset 0x00 reads the VERSION parameter.
- R2: A write to the config word (offset 0x1C) sets `func_crc` from bit 0 (1 = CRC compare) and `sink_sram` from bit 4 (1 = SRAM). The write is ignored while list enable (offset 0x14, bit 0) is 1.
- R3: A write of bit 0 = 1 to the trigger word (offset 0x20) while the list is enabled and the engine is ready raises `walk_start` for exactly the next cycle. Status bit 4 reads 0 from then until the cycle after `walk_done`.
- R4: A trigger write has no effect while list enable is 0 or while a pass is running, and it is not queued.
- R5: The pass CRC is CRC-32 with polynomial 0x04C11DB7, an initial value of all ones, and no reflection or final inversion. Each 32-bit word is fed MSB first. A word counts when `crc_valid` is high during a pass, including in the `walk_done` cycle. The stored reference reads at offset 0x3C.
- R6: The first compare-mode pass after list enable goes from 0 to 1 sets status bit 0 and interrupt-status bit 0, whatever its data.
- R7: A later compare pass sets status bit 0 when its CRC differs from the reference and clears it when the two match. Interrupt-status bit 0 is set on a mismatch. The reference is replaced by the pass CRC only after the comparison.
- R8: Interrupt-status bit 4 (offset 0x34) is set at the end of every pass. Writing 1 to bit 0 or bit 4 clears that bit, but a new event in the same cycle wins over the clear.
- R9: `irq` is high exactly when interrupt status AND interrupt enable (offset 0x30, bits 0 and 4) is non-zero.
- R10: Capture-mode passes leave the error flag and the reference unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| walk_start | output | 1 | One-cycle pass start to the list-walker |
| walk_done | input | 1 | Pass end from the list-walker |
| crc_valid | input | 1 | `crc_data` carries a fetched word |
| crc_data | input | 32 | Fetched word |
| list_en | output | 1 | List enable state |
| func_crc | output | 1 | 1 = compare function selected |
| sink_sram | output | 1 | 1 = SRAM sink selected |
| irq | output | 1 | Level interrupt |

## Verification
Every register write takes effect at the clock edge that samples it. `walk_start` is therefore high in the cycle right after a trigger write, and the status, interrupt status and `irq` move in the cycle right after the `walk_done` edge. Read data is registered, so each read result is due one cycle after the read strobe. The bench drives and samples on the falling edge, so every expected value is compared exactly one clock edge after the stimulus that causes it. It also runs a pass while no read is pending, so ready is checked in the cycle the pass is live.

// File: rtl/snap_pkg.sv
`timescale 1ns/1ps
package snap_pkg;
    localparam int WORD_W = 32;

    localparam logic [7:0] OFS_VERSION = 8'h00;
    localparam logic [7:0] OFS_INFO    = 8'h04;
    localparam logic [7:0] OFS_LISTEN  = 8'h14;
    localparam logic [7:0] OFS_CFG     = 8'h1C;
    localparam logic [7:0] OFS_TRIG    = 8'h20;
    localparam logic [7:0] OFS_STATUS  = 8'h24;
    localparam logic [7:0] OFS_IRQEN   = 8'h30;
    localparam logic [7:0] OFS_IRQST   = 8'h34;
    localparam logic [7:0] OFS_REFCRC  = 8'h3C;

    // place two flags at word bits 4 and 0
    function automatic logic [WORD_W-1:0] pack40(input logic b4, input logic b0);
        logic [WORD_W-1:0] w;
        w = '0;
        w[4] = b4;
        w[0] = b0;
        return w;
    endfunction
endpackage

// File: rtl/snap_crc_step.sv
`timescale 1ns/1ps
module snap_crc_step #(
    parameter int                 CRC_W = 32,
    parameter int                 DAT_W = 32,
    parameter logic [CRC_W-1:0]   POLY  = 32'h04C11DB7
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [DAT_W-1:0] data_in,
    output logic [CRC_W-1:0] crc_out
);
    // unrolled bit-serial division, MSB of the data word first
    logic [CRC_W-1:0] stage [DAT_W+1];

    assign stage[0] = crc_in;

    for (genvar i = 0; i < DAT_W; i++) begin : g_bit
        logic fb;
        assign fb = stage[i][CRC_W-1] ^ data_in[DAT_W-1-i];
        assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_out = stage[DAT_W];
endmodule

// File: rtl/snap_pass_ctrl.sv
`timescale 1ns/1ps
module snap_pass_ctrl #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         trig,
    input  logic         arm,
    input  logic         compare,
    input  logic         crc_valid,
    input  logic [W-1:0] crc_data,
    input  logic         walk_done,
    output logic         busy,
    output logic         start,
    output logic         err,
    output logic [W-1:0] ref_crc,
    output logic         pass_done,
    output logic         mismatch
);
    typedef struct packed {
        logic         busy;
        logic         start;
        logic         first;
        logic         err;
        logic [W-1:0] acc;
        logic [W-1:0] ref_crc;
    } pass_t;

    pass_t q, d;
    logic [W-1:0] folded;

    snap_crc_step #(.CRC_W(W), .DAT_W(W)) u_step (
        .crc_in (q.acc),
        .data_in(crc_data),
        .crc_out(folded)
    );

    logic [W-1:0] acc_next;
    assign acc_next = crc_valid ? folded : q.acc;

    always_comb begin
        d         = q;
        d.start   = 1'b0;
        pass_done = 1'b0;
        mismatch  = 1'b0;
        if (q.busy) begin
            d.acc = acc_next;
            if (walk_done) begin
                d.busy    = 1'b0;
                pass_done = 1'b1;
                if (compare) begin
                    mismatch  = q.first | (acc_next != q.ref_crc);
                    d.err     = mismatch;
                    d.ref_crc = acc_next;
                    d.first   = 1'b0;
                end
            end
        end else if (trig) begin
            d.busy  = 1'b1;
            d.start = 1'b1;
            d.acc   = '1;
        end
        if (arm) d.first = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, start: 1'b0, first: 1'b1, err: 1'b0,
                   acc: '1, ref_crc: '0};
        end else begin
            q <= d;
        end
    end

    assign busy    = q.busy;
    assign start   = q.start;
    assign err     = q.err;
    assign ref_crc = q.ref_crc;

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.start |=> !q.start);
    // R4
    busy_trig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && trig && !walk_done) |=> !q.start);
    // R3
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && walk_done) |=> !q.busy);
    // R6
    first_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && walk_done && compare && q.first) |=> q.err);
    // R10
    capture_keeps_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && walk_done && !compare) |=> $stable(q.ref_crc) && $stable(q.err));
endmodule

// File: rtl/snap_ctrl.sv
`timescale 1ns/1ps
module snap_ctrl
    import snap_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter logic [31:0] VERSION = 32'h0001_0200,
    parameter logic [31:0] INFO    = 32'h0000_0020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              walk_start,
    input  logic              walk_done,
    input  logic              crc_valid,
    input  logic [31:0]       crc_data,
    output logic              list_en,
    output logic              func_crc,
    output logic              sink_sram,
    output logic              irq
);
    typedef struct packed {
        logic        list_en;
        logic        func;
        logic        sink;
        logic [1:0]  irq_en;    // [1] = bit 4, [0] = bit 0
        logic [1:0]  irq_st;
        logic [31:0] rdata;
    } regs_t;

    regs_t q, d;
    logic [7:0] ofs;
    logic busy, err, pass_done, mismatch, trig, arm;
    logic [31:0] ref_crc;

    assign ofs  = 8'(bus_addr);
    assign trig = bus_wr && ofs == OFS_TRIG && bus_wdata[0] && q.list_en;
    assign arm  = bus_wr && ofs == OFS_LISTEN && bus_wdata[0] && !q.list_en;

    snap_pass_ctrl #(.W(WORD_W)) u_pass (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .arm      (arm),
        .compare  (q.func),
        .crc_valid(crc_valid),
        .crc_data (crc_data),
        .walk_done(walk_done),
        .busy     (busy),
        .start    (walk_start),
        .err      (err),
        .ref_crc  (ref_crc),
        .pass_done(pass_done),
        .mismatch (mismatch)
    );

    always_comb begin
        logic [1:0] clr;
        d   = q;
        clr = 2'b00;
        if (bus_wr) begin
            case (ofs)
                OFS_LISTEN: d.list_en = bus_wdata[0];
                OFS_CFG: if (!q.list_en) begin
                    d.func = bus_wdata[0];
                    d.sink = bus_wdata[4];
                end
                OFS_IRQEN: d.irq_en = {bus_wdata[4], bus_wdata[0]};
                OFS_IRQST: clr = {bus_wdata[4], bus_wdata[0]};
                default: ;
            endcase
        end
        d.irq_st = (q.irq_st & ~clr) | {pass_done, mismatch};
        if (bus_rd) begin
            case (ofs)
                OFS_VERSION: d.rdata = VERSION;
                OFS_INFO:    d.rdata = INFO;
                OFS_LISTEN:  d.rdata = pack40(1'b0, q.list_en);
                OFS_CFG:     d.rdata = pack40(q.sink, q.func);
                OFS_STATUS:  d.rdata = pack40(!busy, err);
                OFS_IRQEN:   d.rdata = pack40(q.irq_en[1], q.irq_en[0]);
                OFS_IRQST:   d.rdata = pack40(q.irq_st[1], q.irq_st[0]);
                OFS_REFCRC:  d.rdata = ref_crc;
                default:     d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata = q.rdata;
    assign list_en   = q.list_en;
    assign func_crc  = q.func;
    assign sink_sram = q.sink;
    assign irq       = |(q.irq_st & q.irq_en);

    // R2
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.list_en |=> $stable(q.func) && $stable(q.sink));
    // R8
    w1c_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ofs == OFS_IRQST && bus_wdata[0] && !mismatch) |=> !q.irq_st[0]);
    // R8
    done_sets_bit4_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> q.irq_st[1]);
    // R4
    disabled_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.list_en && !busy) |=> !walk_start);
endmodule

// File: tb/sim_snap_ctrl.sv
`timescale 1ns/1ps
module sim_snap_ctrl;
    localparam logic [31:0] VER = 32'h0001_0200;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 0, bus_rd = 0, walk_done = 0, crc_valid = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, crc_data = 0, bus_rdata;
    logic walk_start, list_en, func_crc, sink_sram, irq;
    int n_chk = 0, n_fail = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    snap_ctrl #(.VERSION(VER)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .walk_start(walk_start), .walk_done(walk_done), .crc_valid(crc_valid),
        .crc_data(crc_data), .list_en(list_en), .func_crc(func_crc),
        .sink_sram(sink_sram), .irq(irq));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // reference CRC-32, non-reflected, MSB-first long division
    function automatic logic [31:0] ref_crc(input logic [31:0] w [3]);
        logic [31:0] r = 32'hFFFF_FFFF;
        foreach (w[k]) begin
            for (int b = 31; b >= 0; b--) begin
                if (r[31] != w[k][b]) r = (r << 1) ^ 32'h04C11DB7;
                else                  r = r << 1;
            end
        end
        return r;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(posedge clk); @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_rd = 1; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_rd = 0; v = bus_rdata;
    endtask

    // trigger, feed three words (last with done), return after done edge
    task automatic run_pass(input logic [31:0] w [3], input string req);
        wr(8'h20, 32'h1);
        check({req, " R3 start pulse"}, {31'b0, walk_start}, 32'h1);
        for (int k = 0; k < 3; k++) begin
            crc_valid = 1; crc_data = w[k]; walk_done = (k == 2);
            @(posedge clk); @(negedge clk);
        end
        crc_valid = 0; walk_done = 0;
    endtask

    task automatic t_reset;
        rd(8'h24, rv); check("R1 status", rv, 32'h10);
        rd(8'h00, rv); check("R1 version", rv, VER);
        rd(8'h34, rv); check("R1 irq status", rv, 32'h0);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 list_en", {31'b0, list_en}, 0);
    endtask

    task automatic t_cfg;
        wr(8'h1C, 32'h11);
        check("R2 func", {31'b0, func_crc}, 1);
        check("R2 sink", {31'b0, sink_sram}, 1);
        wr(8'h20, 32'h1);
        check("R4 disabled trigger", {31'b0, walk_start}, 0);
        wr(8'h14, 32'h1);
        wr(8'h1C, 32'h00);
        rd(8'h1C, rv); check("R2 locked cfg", rv, 32'h11);
    endtask

    task automatic t_compare;
        logic [31:0] a [3] = '{32'h1, 32'h2, 32'h3};
        logic [31:0] b [3] = '{32'hDEAD_BEEF, 32'h0, 32'h5};
        wr(8'h30, 32'h1);
        // first pass: busy check and ignored trigger inside
        wr(8'h20, 32'h1);
        check("R3 start pulse", {31'b0, walk_start}, 1);
        wr(8'h20, 32'h1);
        check("R3 pulse ends", {31'b0, walk_start}, 0);
        check("R4 busy trigger", {31'b0, walk_start}, 0);
        rd(8'h24, rv); check("R3 not ready", rv & 32'h10, 32'h0);
        for (int k = 0; k < 3; k++) begin
            crc_valid = 1; crc_data = a[k]; walk_done = (k == 2);
            @(posedge clk); @(negedge clk);
        end
        crc_valid = 0; walk_done = 0;
        check("R4 no queued start", {31'b0, walk_start}, 0);
        rd(8'h24, rv); check("R6 first pass err", rv, 32'h11);
        rd(8'h3C, rv); check("R5 reference crc", rv, ref_crc(a));
        check("R9 irq on", {31'b0, irq}, 1);
        wr(8'h34, 32'h11);
        check("R9 irq off after clear", {31'b0, irq}, 0);
        rd(8'h34, rv); check("R8 w1c", rv, 32'h0);
        run_pass(a, "match");
        rd(8'h24, rv); check("R7 match clears err", rv, 32'h10);
        rd(8'h34, rv); check("R8 done bit4", rv, 32'h10);
        check("R9 bit4 masked", {31'b0, irq}, 0);
        wr(8'h30, 32'h10);
        check("R9 bit4 enabled", {31'b0, irq}, 1);
        wr(8'h34, 32'h10);
        run_pass(b, "mismatch");
        rd(8'h24, rv); check("R7 mismatch err", rv, 32'h11);
        rd(8'h3C, rv); check("R7 ref replaced", rv, ref_crc(b));
        rd(8'h34, rv); check("R7 irq bit0", rv, 32'h11);
    endtask

    task automatic t_capture_rearm;
        logic [31:0] b [3] = '{32'hDEAD_BEEF, 32'h0, 32'h5};
        logic [31:0] c [3] = '{32'h7, 32'h8, 32'h9};
        wr(8'h14, 32'h0);
        wr(8'h1C, 32'h0);
        wr(8'h14, 32'h1);
        run_pass(c, "capture");
        rd(8'h3C, rv); check("R10 ref kept", rv, ref_crc(b));
        rd(8'h24, rv); check("R10 err kept", rv, 32'h11);
        wr(8'h14, 32'h0);
        wr(8'h1C, 32'h1);
        wr(8'h14, 32'h1);
        wr(8'h34, 32'h11);
        run_pass(b, "rearm");
        rd(8'h24, rv); check("R6 rearm first err", rv, 32'h11);
        rd(8'h34, rv); check("R6 irq status", rv, 32'h11);
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_cfg;
        t_compare;
        t_capture_rearm;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule